// File: doc/BRIEF.md
# Multi-channel SPI master burst engine

This block shifts one parallel word at a time out of a master-mode SPI port. Up to four peripherals share its clock and data lines. Each peripheral has its own select line. Settings are held separately for each channel: clock phase, clock polarity, select polarity, the resting level of the clock line, the resting level of the data line, and whether the select stays asserted across back-to-back bursts. A burst carries 1 to 32 bits, most significant bit first.

A word is handed in through a valid/ready handshake and held until a trigger starts the burst. The trigger is either a software kick, an auto-start setting, or an active-low ready pin, selected by a mode field. Two delays can be programmed. The first is a lead-in, measured in SCLK periods, between select assertion and the first clock edge. The second is a gap, measured in system clocks, after each burst ends. The word shifted in from MISO is presented, right-aligned, together with a one-cycle completion strobe.

Top module: `spi_burst_master`

## Requirements
- R1: `cfg_chan` (0..3) names the channel a burst uses. While the select is active, exactly one `sel` bit is at its active level, and all other `sel` bits stay at their inactive level. Bit i of `cfg_sel_high` sets the active level of `sel[i]`: 1 makes it active-high, 0 makes it active-low. The inactive level is the opposite.
- R2: When the channel's `cfg_cpha` bit is 0, every bit period has two halves. In the first half SCLK sits at the polarity level, and in the second half it sits at the opposite level. MISO is sampled on the clock ending the first half, and MOSI moves to the next bit at the end of the second half.
- R3: When the channel's `cfg_cpha` bit is 1, SCLK takes the opposite of the polarity level in the first half and the polarity level in the second half. MOSI changes at the start of each bit, and MISO is sampled on the clock ending the first half.
- R4: While the select is asserted but no bit is being shifted (lead-in, gap, or a held select), SCLK rests at the channel's `cfg_cpol` level. `cfg_cpol` = 0 means SCLK idles low, and 1 means it idles high.
- R5: While no select is asserted, the levels come from the bits of the channel named by `cfg_chan`. SCLK equals its `cfg_sclk_high_idle` bit, so 0 gives low and 1 gives high. MOSI equals the inverse of its `cfg_mosi_low_idle` bit, so 0 gives high and 1 gives low.
- R6: `cfg_trig_mode` chooses the trigger. With 1, a falling edge on `rdy_n` starts a burst, and an edge seen with no word held is remembered. With 2, a burst starts while `rdy_n` is low. With 0 or 3, a burst starts from `kick` or `cfg_auto`, and `rdy_n` is ignored. In modes 1 and 2, `kick` has no effect.
- R7: When a burst starts with the select not already held, the select asserts first. SCLK then stays idle for `cfg_lead` × 2 × half-period system clocks. During that time MOSI already presents the first bit. A lead of 0 skips the delay.
- R8: After the last bit, the engine waits `cfg_gap` system clocks before it can launch another burst.
- R9: When the channel's `cfg_hold_sel` bit is 1, the select stays asserted after a burst. A word that is triggered when the gap ends is shifted with no lead-in. If none is triggered, the select drops one cycle after the gap ends. When the bit is 0, the select drops on the cycle after the last bit.
- R10: In modes 0 and 3, a burst starts from the idle state once a word is held and either a `kick` has been seen since the previous launch or `cfg_auto` is 1. A `kick` that arrives before the word is kept.
- R11: `cfg_bits_m1` + 1 bits are sent MSB first from `tx_word`. The bits received are placed right-aligned on `rx_word`. `done` is high for exactly one cycle, the cycle after the last bit, and `rx_word` shows the new value on that same cycle.
- R12: Each SCLK half-period lasts `cfg_half_div` system clocks. A value of 0 is treated as 1, so SCLK is the system clock divided by at least 2.
- R13: `tx_ready` is high exactly when no word is held. A word is held from the cycle after it is accepted until the cycle after its burst launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_div | input | 8 | SCLK half-period in system clocks (0 acts as 1) |
| cfg_bits_m1 | input | 5 | Burst length minus one |
| cfg_chan | input | 2 | Channel used by the next burst |
| cfg_cpha | input | 4 | Per-channel clock phase |
| cfg_cpol | input | 4 | Per-channel clock polarity |
| cfg_sel_high | input | 4 | Per-channel select active level |
| cfg_mosi_low_idle | input | 4 | Per-channel MOSI resting level (1 = low) |
| cfg_sclk_high_idle | input | 4 | Per-channel SCLK resting level (1 = high) |
| cfg_hold_sel | input | 4 | Per-channel select hold across bursts |
| cfg_trig_mode | input | 2 | Trigger source select |
| cfg_auto | input | 1 | Launch as soon as a word is held (modes 0, 3) |
| cfg_lead | input | 8 | Select-to-first-edge delay in SCLK periods |
| cfg_gap | input | 8 | Post-burst wait in system clocks |
| kick | input | 1 | Software burst trigger pulse |
| rdy_n | input | 1 | Active-low ready pin |
| tx_word | input | 32 | Word to transmit |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit holding register free |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sel | output | 4 | Channel selects |
| rx_word | output | 32 | Last received word, right-aligned |
| done | output | 1 | One-cycle burst completion strobe |

## Verification
The bench aims at the phase and polarity corners with a one-clock half-period. There, a sample placed in the wrong half would collect neighbouring bits, and a wrong resting level would show as an extra SCLK edge outside the shift window. It checks gap and lead lengths exactly. A launch that slipped into the gap, or a lead-in applied to a held-select follow-on burst, would put every later cycle one or more clocks off. In edge mode, the ready pin is held low across a finished burst, so a design that treats the edge mode as level-sensitive would fire again. In the ready modes, `kick` is pulsed and must not start anything. One-bit and full 32-bit bursts catch errors in the length count and in the right-alignment of `rx_word`.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DW   = 8,
  parameter int NCH  = 4,
  parameter int MAXW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            cfg_half_div,
  input  logic [$clog2(MAXW)-1:0]  cfg_bits_m1,
  input  logic [$clog2(NCH)-1:0]   cfg_chan,
  input  logic [NCH-1:0]           cfg_cpha,
  input  logic [NCH-1:0]           cfg_cpol,
  input  logic [NCH-1:0]           cfg_sel_high,
  input  logic [NCH-1:0]           cfg_mosi_low_idle,
  input  logic [NCH-1:0]           cfg_sclk_high_idle,
  input  logic [NCH-1:0]           cfg_hold_sel,
  input  logic [1:0]               cfg_trig_mode,
  input  logic                     cfg_auto,
  input  logic [DW-1:0]            cfg_lead,
  input  logic [DW-1:0]            cfg_gap,
  input  logic                     kick,
  input  logic                     rdy_n,
  input  logic [MAXW-1:0]          tx_word,
  input  logic                     tx_valid,
  output logic                     tx_ready,
  input  logic                     miso,
  output logic                     sclk,
  output logic                     mosi,
  output logic [NCH-1:0]           sel,
  output logic [MAXW-1:0]          rx_word,
  output logic                     done
);
  localparam int CHW = $clog2(NCH);
  localparam int LW  = $clog2(MAXW);
  localparam int CW  = 2 * DW + 1;
  localparam logic [CW-1:0] CNT_ONE = 1;
  localparam logic [DW-1:0] HC_ONE  = 1;
  localparam logic [LW-1:0] BIT_ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP} st_t;
  st_t st;

  logic [CHW-1:0]  ch;
  logic            sel_on, full, hb, start_pend, fall_pend, rdy_q, done_q;
  logic [MAXW-1:0] hold, word, rx_sh, rx_q;
  logic [LW-1:0]   bit_i, len_q;
  logic [DW-1:0]   hc;
  logic [CW-1:0]   cnt;

  logic [DW-1:0]  half;
  logic [CHW-1:0] vch;
  logic           sw_mode, edge_f, trig, launch, accept;
  logic [CW-1:0]  lead_len;

  assign half     = (cfg_half_div == '0) ? HC_ONE : cfg_half_div;
  assign vch      = sel_on ? ch : cfg_chan;
  assign sw_mode  = !(cfg_trig_mode == 2'd1 || cfg_trig_mode == 2'd2);
  assign edge_f   = rdy_q & ~rdy_n;
  assign trig     = (cfg_trig_mode == 2'd1) ? (fall_pend | edge_f) :
                    (cfg_trig_mode == 2'd2) ? ~rdy_n :
                    (kick | start_pend | cfg_auto);
  assign launch   = (st == S_IDLE) && full && trig;
  assign accept   = tx_valid && !full;
  assign lead_len = (CW'(cfg_lead) * CW'(half)) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ch <= '0; sel_on <= 1'b0; full <= 1'b0; hb <= 1'b0;
      start_pend <= 1'b0; fall_pend <= 1'b0; rdy_q <= 1'b1; done_q <= 1'b0;
      hold <= '0; word <= '0; rx_sh <= '0; rx_q <= '0;
      bit_i <= '0; len_q <= '0; hc <= '0; cnt <= '0;
    end else begin
      rdy_q      <= rdy_n;
      done_q     <= 1'b0;
      full       <= accept ? 1'b1 : (launch ? 1'b0 : full);
      start_pend <= sw_mode & (start_pend | kick) & ~launch;
      fall_pend  <= (cfg_trig_mode == 2'd1) & (fall_pend | edge_f) & ~launch;
      if (accept) hold <= tx_word;
      case (st)
        S_IDLE: begin
          if (launch) begin
            word   <= hold;
            len_q  <= cfg_bits_m1;
            bit_i  <= cfg_bits_m1;
            rx_sh  <= '0;
            hc     <= half - HC_ONE;
            hb     <= 1'b0;
            sel_on <= 1'b1;
            if (!sel_on) ch <= cfg_chan;
            if (sel_on || cfg_lead == '0) st <= S_SHIFT;
            else begin
              st  <= S_LEAD;
              cnt <= lead_len;
            end
          end else if (sel_on) begin
            sel_on <= 1'b0;
          end
        end
        S_LEAD: begin
          if (cnt == CNT_ONE) st <= S_SHIFT;
          else cnt <= cnt - CNT_ONE;
        end
        S_SHIFT: begin
          if (hc != '0) hc <= hc - HC_ONE;
          else begin
            hc <= half - HC_ONE;
            if (!hb) begin
              hb    <= 1'b1;
              rx_sh <= {rx_sh[MAXW-2:0], miso};
            end else begin
              hb <= 1'b0;
              if (bit_i == '0) begin
                done_q <= 1'b1;
                rx_q   <= rx_sh;
                sel_on <= cfg_hold_sel[ch];
                if (cfg_gap == '0) st <= S_IDLE;
                else begin
                  st  <= S_GAP;
                  cnt <= CW'(cfg_gap);
                end
              end else begin
                bit_i <= bit_i - BIT_ONE;
              end
            end
          end
        end
        S_GAP: begin
          if (cnt == CNT_ONE) st <= S_IDLE;
          else cnt <= cnt - CNT_ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk     = !sel_on ? cfg_sclk_high_idle[vch]
                  : (st == S_SHIFT) ? (cfg_cpol[ch] ^ cfg_cpha[ch] ^ hb)
                  : cfg_cpol[ch];
  assign mosi     = (st == S_LEAD || st == S_SHIFT) ? word[bit_i] : ~cfg_mosi_low_idle[vch];
  assign tx_ready = ~full;
  assign rx_word  = rx_q;
  assign done     = done_q;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = (sel_on && ch == CHW'(i)) ? cfg_sel_high[i] : ~cfg_sel_high[i];
  end

  // sample counter used only by the bit-count check
  logic [LW:0] smp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else if (launch) smp <= '0;
    else if (st == S_SHIFT && hc == '0 && !hb) smp <= smp + {{LW{1'b0}}, 1'b1};
  end

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel ^ ~cfg_sel_high) == 32'(sel_on));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_bit_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (smp == {1'b0, len_q} + {{LW{1'b0}}, 1'b1}));

  assert_launch_needs_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_on) |-> $past(full));

  assert_lead_select_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD && $past(st == S_LEAD)) |-> $stable(sel));
endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]  c_div, c_lead, c_gap;
  logic [4:0]  c_len;
  logic [1:0]  c_chan, c_mode;
  logic [3:0]  c_cpha, c_cpol, c_selh, c_mosi_idle, c_sclk_idle, c_hold;
  logic        c_auto, kick, rdy_n, tx_valid, miso;
  logic [31:0] tx_data;
  logic        tx_ready, sclk, mosi, done;
  logic [3:0]  sel;
  logic [31:0] rx_word;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(c_div), .cfg_bits_m1(c_len),
    .cfg_chan(c_chan), .cfg_cpha(c_cpha), .cfg_cpol(c_cpol), .cfg_sel_high(c_selh),
    .cfg_mosi_low_idle(c_mosi_idle), .cfg_sclk_high_idle(c_sclk_idle),
    .cfg_hold_sel(c_hold), .cfg_trig_mode(c_mode), .cfg_auto(c_auto),
    .cfg_lead(c_lead), .cfg_gap(c_gap), .kick(kick), .rdy_n(rdy_n),
    .tx_word(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .miso(miso),
    .sclk(sclk), .mosi(mosi), .sel(sel), .rx_word(rx_word), .done(done));

  // behavioural reference state
  bit          m_on, m_full, m_done;
  int          m_ch;
  logic [31:0] m_rx;
  string       cur_req;
  int          n_chk = 0, n_fail = 0;

  function automatic logic [3:0] e_sel();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (m_on && i == m_ch) ? c_selh[i] : ~c_selh[i];
    return e;
  endfunction
  function automatic logic e_sclk_rest();
    return m_on ? c_cpol[m_ch] : c_sclk_idle[c_chan];
  endfunction
  function automatic logic e_mosi_rest();
    return m_on ? ~c_mosi_idle[m_ch] : ~c_mosi_idle[c_chan];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic step(string tag, logic es, logic em);
    @(negedge clk);
    chk("R1", "sel", 32'(sel), 32'(e_sel()));
    chk(tag, "sclk", 32'(sclk), 32'(es));
    chk(tag, "mosi", 32'(mosi), 32'(em));
    chk("R11", "done", 32'(done), 32'(m_done));
    chk("R11", "rx_word", rx_word, m_rx);
    chk("R13", "tx_ready", 32'(tx_ready), 32'(!m_full));
    m_done = 1'b0;
  endtask

  task automatic step_rest();
    step(cur_req, e_sclk_rest(), e_mosi_rest());
  endtask

  // one burst from the cycle after launch to its last shift cycle
  task automatic body(logic [31:0] txw, logic [31:0] rxw, bit lead);
    int  dv = (c_div == 0) ? 1 : int'(c_div);
    logic a = c_cpol[m_ch] ^ c_cpha[m_ch];
    string st = c_cpha[m_ch] ? "R3 R12" : "R2 R12";
    if (lead) for (int k = 0; k < int'(c_lead) * 2 * dv; k++) step("R7", c_cpol[m_ch], txw[c_len]);
    for (int b = int'(c_len); b >= 0; b--)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < dv; c++) begin
          step(st, (h == 0) ? a : ~a, txw[b]);
          miso = rxw[b];
        end
    m_rx   = (c_len == 5'd31) ? rxw : (rxw & ((32'd1 << (int'(c_len) + 1)) - 32'd1));
    m_done = 1'b1;
  endtask

  task automatic load(logic [31:0] w, logic pulse);
    tx_valid = 1'b1; tx_data = w; kick = pulse;
    m_full = 1'b1;
    step_rest();
    tx_valid = 1'b0; kick = 1'b0;
  endtask

  task automatic go(int chn);
    m_on = 1'b1; m_ch = chn; m_full = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; c_div = 8'd2; c_lead = 8'd1; c_gap = 8'd0; c_len = 5'd7;
    c_chan = 2'd0; c_mode = 2'd0; c_cpha = '0; c_cpol = '0; c_selh = '0;
    c_mosi_idle = '0; c_sclk_idle = '0; c_hold = '0; c_auto = 1'b0;
    kick = 1'b0; rdy_n = 1'b1; tx_valid = 1'b0; tx_data = '0; miso = 1'b0;
    m_on = 0; m_full = 0; m_done = 0; m_ch = 0; m_rx = '0;

    // reset state and resting levels (R5)
    cur_req = "R5";
    step_rest(); step_rest();
    rst_n = 1'b1;
    step_rest();
    c_chan = 2'd3; c_mosi_idle = 4'b1000; c_sclk_idle = 4'b1000;
    step_rest();
    c_chan = 2'd2; c_selh = 4'b0100;
    step_rest();

    // channel 0, phase 0, polarity 0, reserved trigger mode acts as software (R2 R6 R7 R10)
    c_chan = 2'd0; c_mode = 2'd3; c_len = 5'd7; c_div = 8'd2; c_lead = 8'd1;
    cur_req = "R10";
    load(32'h0000_00A5, 1'b1);
    go(0); body(32'h0000_00A5, 32'h0000_003C, 1'b1);
    m_on = 0; step_rest(); step_rest(); step_rest();

    // channel 2, phase 1, polarity 1, active-high select, 32 bits, zero divider, gap (R3 R4 R8 R12)
    c_chan = 2'd2; c_mode = 2'd0; c_cpol = 4'b0100; c_cpha = 4'b0100;
    c_len = 5'd31; c_div = 8'd0; c_lead = 8'd0; c_gap = 8'd3;
    cur_req = "R12";
    load(32'hDEAD_BEEF, 1'b1);
    go(2); body(32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
    tx_valid = 1'b1; tx_data = 32'h8000_0001; kick = 1'b1;
    cur_req = "R8";
    m_on = 0; m_full = 1;
    step_rest();
    tx_valid = 1'b0; kick = 1'b0;
    step_rest(); step_rest();
    step_rest();
    go(2); body(32'h8000_0001, 32'hFFFF_0000, 1'b0);
    m_on = 0; step_rest(); step_rest(); step_rest(); step_rest();

    // channel 1, held select, auto start, lead-in only on the first burst (R4 R9 R10)
    c_chan = 2'd1; c_cpol = 4'b0000; c_cpha = 4'b0010; c_hold = 4'b0010;
    c_len = 5'd11; c_div = 8'd2; c_lead = 8'd2; c_gap = 8'd2; c_auto = 1'b1;
    cur_req = "R9";
    load(32'h0000_0ABC, 1'b0);
    go(1); body(32'h0000_0ABC, 32'h0000_0F0F, 1'b1);
    tx_valid = 1'b1; tx_data = 32'h0000_0555;
    m_full = 1;
    cur_req = "R4";
    step_rest();
    tx_valid = 1'b0;
    step_rest();
    cur_req = "R9";
    step_rest();
    m_full = 0; body(32'h0000_0555, 32'h0000_0AAA, 1'b0);
    step_rest(); step_rest(); step_rest();
    m_on = 0; step_rest(); step_rest();
    c_auto = 1'b0; c_hold = 4'b0000;

    // falling-edge ready trigger; kick ignored; low level alone does not retrigger (R6)
    c_chan = 2'd0; c_mode = 2'd1; c_len = 5'd7; c_div = 8'd2; c_lead = 8'd1; c_gap = 8'd0;
    cur_req = "R6";
    load(32'h0000_00C3, 1'b1);
    step_rest(); step_rest(); step_rest();
    rdy_n = 1'b0;
    go(0); body(32'h0000_00C3, 32'h0000_0099, 1'b1);
    m_on = 0; step_rest(); step_rest();
    load(32'h0000_0011, 1'b0);
    step_rest(); step_rest(); step_rest();
    rdy_n = 1'b1; step_rest();
    rdy_n = 1'b0;
    go(0); body(32'h0000_0011, 32'h0000_00EE, 1'b1);
    rdy_n = 1'b1;
    m_on = 0; step_rest(); step_rest();

    // low-level ready trigger (R6)
    c_mode = 2'd2;
    load(32'h0000_005A, 1'b0);
    step_rest(); step_rest();
    rdy_n = 1'b0;
    go(0); body(32'h0000_005A, 32'h0000_0081, 1'b1);
    rdy_n = 1'b1;
    m_on = 0; step_rest(); step_rest(); step_rest();

    // one-bit burst on channel 3, polarity 1 phase 0, divider 3 (R2 R11)
    c_mode = 2'd0; c_chan = 2'd3; c_cpol = 4'b1000; c_cpha = 4'b0000;
    c_len = 5'd0; c_div = 8'd3; c_lead = 8'd0;
    cur_req = "R11";
    load(32'h0000_0001, 1'b1);
    go(3); body(32'h0000_0001, 32'h0000_0001, 1'b0);
    m_on = 0; step_rest(); step_rest(); step_rest();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule